// File: doc/BRIEF.md
# Buffered PWM Timebase

This block is the counting and compare core of a pulse-width modulator. A 16-bit counter is advanced by a prescaler that divides the system clock by 1, 2, 4 or 16. The counter runs either as a down-counter that reloads from the period value (edge-aligned) or as an up/down counter between zero and the period value (center-aligned). Three compare units each produce one raw waveform. A later stage turns each raw waveform into a pair of channels: compare unit k serves channels 2k and 2k+1.

Software writes a period value and three compare values through a simple write port. These writes land in shadow registers. The active values change only when a load request is pending and the counter passes through zero. A period event pulse fires once per period, either when the counter passes zero or when it reaches the period value. The pulse also sets a sticky interrupt flag, which is cleared by writing 1.

Top module: `pwmTimebase`

## Requirements
- R1: After reset the counter reads 0, every raw output is 1 (all active compare values are 0), and the period event, the interrupt flag and the load-pending output are all 0.
- R2: The prescaler code is bits [1:0] of a write to address 14. Code 0, 1, 2 and 3 make the counter step once every 1, 2, 4 and 16 clocks respectively. The code takes effect without a load request.
- R3: With bit 2 of the control word clear (edge mode), the counter counts down from the active period P to 0 and then reloads P. Consecutive period events are (P+1)×divider clocks apart.
- R4: With bit 2 set (center mode), the counter counts up from 0 to P and then back down to 0, moving by exactly one per step. Consecutive period events are 2×P×divider clocks apart.
- R5: While the active period is 0, the counter stays at 0 and no period event fires.
- R6: Writes to address 0 (period) and addresses 1 to 3 (compare units 0 to 2) change only the shadow copies. Writing 1 to bit 4 of the control word sets load-pending. The shadows are copied to the active registers only on a counter step taken at count 0, and load-pending clears on that step.
- R7: Raw output k is 1 exactly when the counter is less than or equal to the active compare value k. A compare value above the period therefore keeps the output at 1 for the whole period.
- R8: The period event is a one-clock pulse on a counter step taken at count 0 (bit 3 clear) or at count P (bit 3 set). It fires only when the active period is nonzero.
- R9: The interrupt flag sets together with each period event. It stays set until a write to address 15 with bit 0 at 1 clears it, and a period event in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one clock |
| wrAddr | input | 4 | Write address: 0 period, 1..3 compare, 14 control, 15 flag clear |
| wrData | input | 16 | Write data |
| pwmRaw | output | 3 | Raw waveform per compare unit |
| cntVal | output | 16 | Current counter value |
| periodEvt | output | 1 | One-clock period event pulse |
| irqFlag | output | 1 | Sticky period interrupt flag |
| loadBusy | output | 1 | Load request pending |

## Verification
A write presented before a rising edge is registered at that edge. A load request is therefore visible on `loadBusy` at the next falling edge, and its commit happens on the first later counter step at zero. Counter, raw outputs, event and flag all change at the same rising edge as the counter step that causes them, so they are due one falling edge after that step. The bench runs a cycle-level reference model at each rising edge and queues the expected outputs. A monitor pops and compares them at the following falling edge. Period lengths are checked separately by counting the clocks between two event pulses, after skipping two events so that the new settings have settled.

// File: rtl/pwm_tb_pkg.sv
package pwmTbPkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP0   = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd14;
  localparam logic [ADDR_W-1:0] ADDR_CLR    = 4'd15;

  // control word bit positions
  localparam int CB_PRESC  = 0;  // two bits
  localparam int CB_CENTER = 2;
  localparam int CB_EVTSEL = 3;
  localparam int CB_LOAD   = 4;

  localparam int PRE_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic centerMode;
    logic evtAtMatch;
    logic commitEn;
  } tbStrobe_t;

  function automatic logic [PRE_W-1:0] divLast(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd3;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwmTbPrescaler
  import pwmTbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] prescCode,
  output logic       tick
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] limit;

  assign limit = divLast(prescCode);
  // >= so that shrinking the divider never stalls the counter
  assign tick  = (preCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end
endmodule

// File: rtl/pwm_tb_ctrl.sv
module pwmTbCtrl
  import pwmTbPkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_UNITS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [CNT_W-1:0]           wrData,
  input  logic                       boundaryTick,
  input  logic                       evtNow,
  output logic [1:0]                 prescCode,
  output tbStrobe_t                  strobe,
  output logic [CNT_W-1:0]           shPer,
  output logic [NUM_UNITS*CNT_W-1:0] shCmp,
  output logic                       irqFlag
);
  logic ctrlWr, clrWr, perWr;
  logic centerQ, evtSelQ, loadReq;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign clrWr  = wrEn && (wrAddr == ADDR_CLR) && wrData[0];
  assign perWr  = wrEn && (wrAddr == ADDR_PERIOD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCode <= '0;
      centerQ   <= 1'b0;
      evtSelQ   <= 1'b0;
    end else if (ctrlWr) begin
      prescCode <= wrData[CB_PRESC +: 2];
      centerQ   <= wrData[CB_CENTER];
      evtSelQ   <= wrData[CB_EVTSEL];
    end
  end

  // a new request in the commit clock survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadReq <= 1'b0;
    else       loadReq <= (loadReq && !boundaryTick) || (ctrlWr && wrData[CB_LOAD]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      shPer <= '0;
    else if (perWr) shPer <= wrData;
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gShadow
    localparam logic [ADDR_W-1:0] UNIT_ADDR = ADDR_CMP0 + ADDR_W'(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              shCmp[g*CNT_W +: CNT_W] <= '0;
      else if (wrEn && (wrAddr == UNIT_ADDR)) shCmp[g*CNT_W +: CNT_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqFlag <= 1'b0;
    else       irqFlag <= (irqFlag && !clrWr) || evtNow;
  end

  assign strobe.centerMode = centerQ;
  assign strobe.evtAtMatch = evtSelQ;
  assign strobe.commitEn   = loadReq;
endmodule

// File: rtl/pwm_tb_datapath.sv
module pwmTbDatapath
  import pwmTbPkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_UNITS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tick,
  input  tbStrobe_t                  strobe,
  input  logic [CNT_W-1:0]           shPer,
  input  logic [NUM_UNITS*CNT_W-1:0] shCmp,
  output logic                       boundaryTick,
  output logic                       evtNow,
  output logic [CNT_W-1:0]           cntVal,
  output logic [NUM_UNITS-1:0]       pwmRaw,
  output logic                       periodEvt
);
  logic [CNT_W-1:0] actPer, nextPer, cntNext;
  logic             dirUp, dirNext, commit, atZero;

  assign atZero       = (cntVal == '0);
  assign boundaryTick = tick && atZero;
  assign commit       = boundaryTick && strobe.commitEn;
  assign nextPer      = commit ? shPer : actPer;
  assign evtNow       = tick && (actPer != '0) &&
                        (strobe.evtAtMatch ? (cntVal == actPer) : atZero);

  always_comb begin
    cntNext = cntVal;
    dirNext = dirUp;
    if (tick) begin
      if (atZero) begin
        dirNext = 1'b1;
        if (strobe.centerMode) cntNext = (nextPer != '0) ? CNT_W'(1) : '0;
        else                   cntNext = nextPer;
      end else if (!strobe.centerMode) begin
        cntNext = cntVal - 1'b1;
      end else if (dirUp && (cntVal < actPer)) begin
        cntNext = cntVal + 1'b1;
      end else begin
        dirNext = 1'b0;
        cntNext = cntVal - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal    <= '0;
      dirUp     <= 1'b1;
      actPer    <= '0;
      periodEvt <= 1'b0;
    end else begin
      cntVal    <= cntNext;
      dirUp     <= dirNext;
      actPer    <= nextPer;
      periodEvt <= evtNow;
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnit
    logic [CNT_W-1:0] actCmp;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       actCmp <= '0;
      else if (commit) actCmp <= shCmp[g*CNT_W +: CNT_W];
    end
    assign pwmRaw[g] = (cntVal <= actCmp);
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwmTimebase
  import pwmTbPkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_UNITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [CNT_W-1:0]     wrData,
  output logic [NUM_UNITS-1:0] pwmRaw,
  output logic [CNT_W-1:0]     cntVal,
  output logic                 periodEvt,
  output logic                 irqFlag,
  output logic                 loadBusy
);
  logic [1:0]                 prescCode;
  logic                       tick, boundaryTick, evtNow;
  tbStrobe_t                  strobe;
  logic [CNT_W-1:0]           shPer;
  logic [NUM_UNITS*CNT_W-1:0] shCmp;

  pwmTbPrescaler u_pre (
    .clk       (clk),
    .rstN      (rstN),
    .prescCode (prescCode),
    .tick      (tick)
  );

  pwmTbCtrl #(.CNT_W(CNT_W), .NUM_UNITS(NUM_UNITS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .boundaryTick (boundaryTick),
    .evtNow       (evtNow),
    .prescCode    (prescCode),
    .strobe       (strobe),
    .shPer        (shPer),
    .shCmp        (shCmp),
    .irqFlag      (irqFlag)
  );

  pwmTbDatapath #(.CNT_W(CNT_W), .NUM_UNITS(NUM_UNITS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .strobe       (strobe),
    .shPer        (shPer),
    .shCmp        (shCmp),
    .boundaryTick (boundaryTick),
    .evtNow       (evtNow),
    .cntVal       (cntVal),
    .pwmRaw       (pwmRaw),
    .periodEvt    (periodEvt)
  );

  assign loadBusy = strobe.commitEn;
endmodule

// File: rtl/pwm_tb_checker.sv
module pwmTbChecker
  import pwmTbPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrBit0,
  input logic              wrLoadBit,
  input logic [CNT_W-1:0]  cntVal,
  input logic              periodEvt,
  input logic              irqFlag,
  input logic              loadBusy
);
  logic clrReq;
  assign clrReq = wrEn && (wrAddr == ADDR_CLR) && wrBit0;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |=> !periodEvt);

  a_r9_flag_follows_event: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |-> irqFlag);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !clrReq) |=> irqFlag);

  a_r6_load_request_sets: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == ADDR_CTRL) && wrLoadBit) |=> loadBusy);

  a_r6_commit_only_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (loadBusy && (cntVal != '0)) |=> loadBusy);

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal != '0) |=> ((cntVal == $past(cntVal)) ||
                        (cntVal == $past(cntVal) - 1'b1) ||
                        (cntVal == $past(cntVal) + 1'b1)));
endmodule

bind pwmTimebase pwmTbChecker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrBit0    (wrData[0]),
  .wrLoadBit (wrData[4]),
  .cntVal    (cntVal),
  .periodEvt (periodEvt),
  .irqFlag   (irqFlag),
  .loadBusy  (loadBusy)
);

// File: tb/test_pwmTimebase.sv
`timescale 1ns/1ps
module test_pwmTimebase;
  localparam int W = 16;
  localparam int U = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [U-1:0] pwmRaw;
  logic [W-1:0] cntVal;
  logic         periodEvt, irqFlag, loadBusy;

  int nChecks = 0;
  int nFail = 0;
  int evtSeen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwmTimebase i_pwmTimebase (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmRaw(pwmRaw), .cntVal(cntVal), .periodEvt(periodEvt),
    .irqFlag(irqFlag), .loadBusy(loadBusy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- reference model + scoreboard ----------------
  typedef struct {
    int unsigned cnt;
    bit [U-1:0]  pwm;
    bit          evt, irq, busy, center;
  } expItem_t;

  expItem_t expQ[$];

  int unsigned mPer, mShPer, mCnt, mPre;
  int unsigned mCmp[U], mShCmp[U];
  bit mUp, mLoad, mIrq, mCenter, mSel;
  int mCode;

  always @(posedge clk) begin
    if (!rstN) begin
      mPer = 0; mShPer = 0; mCnt = 0; mPre = 0; mUp = 1; mLoad = 0; mIrq = 0;
      mCenter = 0; mSel = 0; mCode = 0;
      for (int k = 0; k < U; k++) begin mCmp[k] = 0; mShCmp[k] = 0; end
    end else begin
      int div;
      bit tk, ev, commit, clr, ldW;
      int unsigned nPer, nCnt;
      expItem_t it;
      div = (mCode == 0) ? 1 : (mCode == 1) ? 2 : (mCode == 2) ? 4 : 16;
      tk = (mPre >= div - 1);
      ev = tk && (mPer != 0) && (mSel ? (mCnt == mPer) : (mCnt == 0));
      commit = tk && (mCnt == 0) && mLoad;
      nPer = commit ? mShPer : mPer;
      nCnt = mCnt;
      if (tk) begin
        if (mCnt == 0) begin
          mUp = 1;
          nCnt = mCenter ? ((nPer != 0) ? 1 : 0) : nPer;
        end else if (!mCenter) nCnt = mCnt - 1;
        else if (mUp && mCnt < mPer) nCnt = mCnt + 1;
        else begin mUp = 0; nCnt = mCnt - 1; end
      end
      if (commit) for (int k = 0; k < U; k++) mCmp[k] = mShCmp[k];
      mPer = nPer;
      mCnt = nCnt;
      mPre = tk ? 0 : mPre + 1;
      clr = wrEn && wrAddr == 4'd15 && wrData[0];
      ldW = wrEn && wrAddr == 4'd14 && wrData[4];
      mIrq = (mIrq && !clr) || ev;
      mLoad = (mLoad && !commit) || ldW;
      it.center = mCenter;
      if (wrEn && wrAddr == 4'd14) begin
        mCode = int'(wrData[1:0]); mCenter = wrData[2]; mSel = wrData[3];
      end
      if (wrEn && wrAddr == 4'd0) mShPer = wrData;
      for (int k = 0; k < U; k++)
        if (wrEn && wrAddr == 4'(k + 1)) mShCmp[k] = wrData;
      it.cnt = mCnt;
      for (int k = 0; k < U; k++) it.pwm[k] = (mCnt <= mCmp[k]);
      it.evt = ev; it.irq = mIrq; it.busy = mLoad;
      expQ.push_back(it);
    end
  end

  always @(negedge clk) begin
    if (periodEvt) evtSeen++;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(cntVal == e.cnt, e.center ? "R4 center count" : "R3 edge count", cntVal, e.cnt);
      check(pwmRaw == e.pwm, "R7 raw outputs", pwmRaw, e.pwm);
      check(periodEvt == e.evt, "R8 period event", periodEvt, e.evt);
      check(irqFlag == e.irq, "R9 interrupt flag", irqFlag, e.irq);
      check(loadBusy == e.busy, "R6 load pending", loadBusy, e.busy);
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ctrlW(input int code, input bit center, input bit sel, input bit load);
    wr(4'd14, W'({load, sel, center, 2'(code)}));
  endtask

  task automatic measureGap(input int expGap, input string req);
    int seen = 0;
    int gap = 0;
    int guard = 0;
    while (seen < 2 && guard < 20000) begin
      @(negedge clk); guard++;
      if (periodEvt) seen++;
    end
    do begin
      @(negedge clk); gap++; guard++;
    end while (!periodEvt && guard < 20000);
    check(gap == expGap, req, gap, expGap);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cntVal == 0, "R1 counter", cntVal, 0);
    check(pwmRaw == 3'b111, "R1 raw outputs", pwmRaw, 3'b111);
    check(periodEvt == 0 && irqFlag == 0 && loadBusy == 0, "R1 event/flag/pending",
          {periodEvt, irqFlag, loadBusy}, 0);

    // R5 idle with zero period
    repeat (40) @(negedge clk);
    check(cntVal == 0, "R5 halted counter", cntVal, 0);
    check(evtSeen == 0, "R5 no events", evtSeen, 0);

    // R3 edge mode, period 9
    wr(4'd0, 16'd9); wr(4'd1, 16'd3); wr(4'd2, 16'd0); wr(4'd3, 16'd12);
    ctrlW(0, 0, 0, 1);
    check(loadBusy == 1, "R6 load pending after request", loadBusy, 1);
    measureGap(10, "R3 edge period");

    // R2 prescaler codes
    ctrlW(1, 0, 0, 0); measureGap(20, "R2 divide by 2");
    ctrlW(2, 0, 0, 0); measureGap(40, "R2 divide by 4");
    ctrlW(3, 0, 0, 0); measureGap(160, "R2 divide by 16");

    // R8 event at period match
    ctrlW(0, 0, 1, 0); measureGap(10, "R8 match event spacing");

    // R4 center mode, period 6
    wr(4'd0, 16'd6);
    ctrlW(0, 1, 1, 1); measureGap(12, "R4 center period");

    // R6 shadow held until load request
    wr(4'd0, 16'd4);
    measureGap(12, "R6 shadow not yet active");
    ctrlW(0, 1, 1, 1); measureGap(8, "R6 committed period");

    // R9 clear right after an event
    do @(negedge clk); while (!periodEvt);
    wrEn = 1'b1; wrAddr = 4'd15; wrData = 16'd1;
    @(negedge clk);
    wrEn = 1'b0;
    check(irqFlag == 0, "R9 flag cleared", irqFlag, 0);
    do @(negedge clk); while (!periodEvt);
    check(irqFlag == 1, "R9 flag set again", irqFlag, 1);

    // R7 compare above period: full duty
    wr(4'd1, 16'd20);
    ctrlW(0, 0, 0, 1);
    measureGap(5, "R3 edge period 4");
    repeat (12) begin
      @(negedge clk);
      check(pwmRaw[0] == 1, "R7 full duty", pwmRaw[0], 1);
    end

    // R5 zero period halts
    wr(4'd0, 16'd0);
    ctrlW(0, 0, 0, 1);
    repeat (30) @(negedge clk);
    evtSeen = 0;
    repeat (100) @(negedge clk);
    check(evtSeen == 0, "R5 no events after halt", evtSeen, 0);
    check(cntVal == 0, "R5 counter held", cntVal, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule